// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Slave

This block is a two-wire serial slave that gives a bus master access to a small bank of 8-bit configuration registers. It watches the clock and data lines through two-stage synchronizers and recognises start, repeated-start and stop conditions. It drives the data line open-drain, through a pull-low enable. A write transaction carries the device address with the write bit, a starting register index, an explicit count byte, and then that many data bytes. These bytes are stored at consecutive indices.

A read transaction first sets the index with a write-addressed header. It then issues a repeated start and the read-address byte. The slave answers with a count byte and then streams register contents from the index onward for as long as the master acknowledges. The whole register bank is also presented as a flat parallel vector, so the surrounding logic can use the settings directly.

Top module: `smb_idx_slave`

## Requirements
- R1: After reset every register reads 00h on the parallel port and the slave does not pull the data line low.
- R2: The slave acknowledges the write-address byte D2h (7-bit address 69h followed by R/W = 0). Any address byte other than D2h, or D3h after a valid index, is not acknowledged, and the rest of that transaction has no effect.
- R3: In a write, the byte after the address is the starting index and the next byte is the count N. The following N data bytes are each acknowledged and stored at consecutive indices.
- R4: A count byte of 00h is not acknowledged. Every data byte after it, up to the next start condition, is ignored and left unacknowledged.
- R5: Data bytes beyond the N announced in a write are not acknowledged and do not change any register.
- R6: The register index is taken modulo the bank depth of 8 and auto-increments after each data byte, wrapping from 7 to 0. This holds for both writes and reads.
- R7: After a write-addressed header with an index and a repeated start, the read-address byte D3h is acknowledged. The slave then sends the count byte, which is 8 (its reset value), most significant bit first. After that it sends register data starting at the index.
- R8: When the master does not acknowledge a byte in a read, the slave releases the data line and sends nothing more. A following stop returns it to idle, ready for a new transaction.
- R9: A single-byte write (count 01h) changes exactly one register. A single-byte read returns the count byte and then the register at the index, and is ended with a not-acknowledge and a stop.
- R10: The slave changes its data-line drive only while the bus clock is low.
- R11: A read-address byte D3h that follows a stop, with no index set since then, is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_bank_o | output | 64 | All registers, index i at bits [8i+7:8i] |

## Verification
The slave's acknowledge decision and the register write land on the same system-clock edge. The drive change that ends an acknowledge also happens in the same cycle as the load of the next transmit bit. A block write whose count runs out mid-stream, and a read stopped by a not-acknowledge, each put these paired actions next to each other. The parallel port is judged against a register model kept in the bench, and the acknowledge bits against the count. A monitor also counts any drive change seen while the clock line is high.

// File: rtl/smb_pkg.sv
// Shared types for the indexed block-transfer slave.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // waiting for a start condition
        ST_ADDR,    // receiving the address byte
        ST_OFFS,    // receiving the starting index
        ST_CNT,     // receiving the count byte
        ST_WDATA,   // receiving data bytes
        ST_ACK,     // holding the acknowledge bit
        ST_TX,      // shifting a byte out to the master
        ST_MACK,    // sampling the master's acknowledge
        ST_IGNORE   // silent until the next start or stop
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
// Brings the bus clock and data lines into the system clock domain and
// flags clock edges plus start and stop conditions.
// Assumes: the system clock samples each bus phase several times; idle bus is high.
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_d;
    logic       sda_d;

    // Two-stage synchronizers plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    // Edge and bus-condition decode from current and delayed samples.
    always_comb begin
        scl_s    = scl_ff[1];
        sda_s    = sda_ff[1];
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_ev = scl_s & scl_d & sda_d & ~sda_s;
        stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/smb_regbank.sv
// Bank of DEPTH registers, each W bits wide, with one write port, one
// combinational read port and a flat parallel view of all entries.
// Assumes: DEPTH is a power of two.
module smb_regbank #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [W-1:0]       wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [W-1:0]       rd_data,
    output logic [DEPTH*W-1:0] bank_flat
);
    logic [W-1:0] mem [DEPTH];

    // Register storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port.
    always_comb rd_data = mem[rd_addr];

    // Flatten the bank for the parallel port.
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign bank_flat[g*W +: W] = mem[g];
    end
endmodule

// File: rtl/smb_idx_fsm.sv
// Protocol engine: shifts bytes in and out, decides acknowledges, tracks
// the register index and the remaining write count.
// Assumes: events come from smb_line_sync; drive changes only on clock fall.
module smb_idx_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         DEPTH    = 8,
    parameter logic [7:0] RD_COUNT = 8'd8,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);
    smb_state_e    state;
    smb_state_e    ack_next;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [7:0]    txreg;
    logic [AW-1:0] ptr;
    logic [7:0]    remain;
    logic          have_offs;
    logic          mack_ok;

    // Read port follows the live index.
    always_comb rd_addr = ptr;

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ack_next  <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            remain    <= '0;
            have_offs <= 1'b0;
            mack_ok   <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_ev) begin
                state     <= ST_IDLE;
                sda_oe    <= 1'b0;
                have_offs <= 1'b0;
            end else if (start_ev) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_OFFS, ST_CNT, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            state  <= ST_IGNORE;
                            case (state)
                                ST_ADDR: begin
                                    if (shreg == {DEV_ADDR, 1'b0}) begin
                                        sda_oe   <= 1'b1;
                                        state    <= ST_ACK;
                                        ack_next <= ST_OFFS;
                                    end else if (shreg == {DEV_ADDR, 1'b1} && have_offs) begin
                                        sda_oe   <= 1'b1;
                                        state    <= ST_ACK;
                                        ack_next <= ST_TX;
                                        txreg    <= RD_COUNT;
                                    end
                                end
                                ST_OFFS: begin
                                    ptr       <= shreg[AW-1:0];
                                    have_offs <= 1'b1;
                                    sda_oe    <= 1'b1;
                                    state     <= ST_ACK;
                                    ack_next  <= ST_CNT;
                                end
                                ST_CNT: begin
                                    if (shreg != 8'd0) begin
                                        remain   <= shreg;
                                        sda_oe   <= 1'b1;
                                        state    <= ST_ACK;
                                        ack_next <= ST_WDATA;
                                    end
                                end
                                default: begin
                                    if (remain != 8'd0) begin
                                        wr_en    <= 1'b1;
                                        wr_addr  <= ptr;
                                        wr_data  <= shreg;
                                        ptr      <= ptr + 1'b1;
                                        remain   <= remain - 8'd1;
                                        sda_oe   <= 1'b1;
                                        state    <= ST_ACK;
                                        ack_next <= ST_WDATA;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state  <= ack_next;
                            bitcnt <= '0;
                            sda_oe <= (ack_next == ST_TX) ? ~txreg[7] : 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_MACK;
                            end else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                sda_oe <= ~txreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                txreg  <= rd_data;
                                ptr    <= ptr + 1'b1;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_idx_slave.sv
// Top level: line synchronizer, protocol engine and register bank.
// Assumes: open-drain pad outside; sda_oe = 1 pulls the line low.
module smb_idx_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         DEPTH    = 8,
    parameter logic [7:0] RD_COUNT = 8'd8,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [DEPTH*8-1:0] reg_bank_o
);
    logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0]    wr_data, rd_data;

    smb_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    smb_idx_fsm #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH), .RD_COUNT(RD_COUNT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    smb_regbank #(.DEPTH(DEPTH), .W(8)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .bank_flat(reg_bank_o)
    );
endmodule

// File: rtl/smb_idx_slave_chk.sv
// Property checker for smb_idx_slave, attached through bind.
// Assumes: bound inside the top so start_ev and stop_ev are visible.
module smb_idx_slave_chk #(
    parameter int DEPTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               sda_oe,
    input logic               start_ev,
    input logic               stop_ev,
    input logic [DEPTH*8-1:0] reg_bank_o
);
    // R10: drive only changes while the clock line is low.
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R3 / R5: a register update only happens under an acknowledge.
    p_write_under_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_bank_o != $past(reg_bank_o)) |-> sda_oe);

    // R8: a stop leaves the line released.
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R2: a start leaves the line released.
    p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);
endmodule

bind smb_idx_slave smb_idx_slave_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .start_ev(start_ev), .stop_ev(stop_ev), .reg_bank_o(reg_bank_o)
);

// File: tb/tb_smb_idx_slave.sv
// Directed bench: a bus-master model drives the clock and data lines,
// one task per scenario, each checking its own results.
module tb_smb_idx_slave;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic [63:0] reg_bank_o;
    logic        sda_line;
    logic [7:0]  model [8];
    int          n_chk = 0;
    int          n_fail = 0;
    int          hi_changes = 0;
    logic        prev_oe = 1'b0;

    always #10 clk = ~clk;
    assign sda_line = ~(m_low | sda_oe);

    smb_idx_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_bank_o(reg_bank_o)
    );

    // R10 monitor: count drive changes seen while the clock line is high.
    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && m_scl) hi_changes++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < 8; i++) chk(tag, reg_bank_o[i*8 +: 8], model[i]);
    endtask

    task automatic bus_start();
        m_low = 1'b0; m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic do_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            m_scl = 1'b0;
        end
        m_low = do_ack; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_low = 1'b0;
    endtask

    // Block write with expected acknowledges, updates the model.
    task automatic do_write(input string tag, input logic [7:0] offs,
                            input logic [7:0] cnt, input logic [7:0] d [],
                            input int n_ok);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk({tag, " addr ack"}, a, 1);
        send_byte(offs, a);  chk({tag, " index ack"}, a, 1);
        send_byte(cnt, a);   chk({tag, " count ack"}, a, cnt != 0);
        for (int i = 0; i < d.size(); i++) begin
            send_byte(d[i], a);
            chk({tag, " data ack"}, a, i < n_ok);
            if (i < n_ok) model[(offs + i) % 8] = d[i];
        end
        bus_stop();
        tick(Q);
        check_bank(tag);
    endtask

    // Block read: header, restart, count byte, then n data bytes, last one NACKed.
    task automatic do_read(input string tag, input logic [7:0] offs, input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a); chk({tag, " addr ack"}, a, 1);
        send_byte(offs, a);  chk({tag, " index ack"}, a, 1);
        bus_rstart();
        send_byte(8'hD3, a); chk({tag, " read addr ack"}, a, 1);
        recv_byte(1'b1, b);  chk({tag, " R7 count byte"}, b, 8'd8);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk({tag, " data"}, b, model[(offs + i) % 8]);
        end
        tick(Q);
        chk({tag, " R8 released after nack"}, sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 no drive", sda_oe, 0);
        check_bank("R1 bank clear");
    endtask

    task automatic t_block_write();
        do_write("R3 block write", 8'd2, 8'd3, '{8'hA1, 8'hB2, 8'hC3}, 3);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'hA0, a); chk("R2 foreign addr nack", a, 0);
        send_byte(8'h00, a); chk("R2 ignored index", a, 0);
        send_byte(8'h01, a);
        send_byte(8'hEE, a); chk("R2 ignored data", a, 0);
        bus_stop();
        tick(Q);
        check_bank("R2 bank unchanged");
    endtask

    task automatic t_zero_count();
        do_write("R4 zero count", 8'd0, 8'd0, '{8'h55, 8'h66}, 0);
    endtask

    task automatic t_overrun();
        do_write("R5 overrun", 8'd5, 8'd1, '{8'h11, 8'h22, 8'h33}, 1);
    endtask

    task automatic t_wrap();
        do_write("R6 wrap write", 8'd6, 8'd4, '{8'h61, 8'h71, 8'h01, 8'h13}, 4);
        do_write("R6 index modulo", 8'h0B, 8'd1, '{8'h3C}, 1);
        do_read("R6 wrap read", 8'd7, 2);
    endtask

    task automatic t_block_read();
        do_read("R7 block read", 8'd2, 3);
        do_read("R8 early stop", 8'd0, 1);
    endtask

    task automatic t_single();
        do_write("R9 single write", 8'd4, 8'd1, '{8'h5A}, 1);
        do_read("R9 single read", 8'd4, 1);
    endtask

    task automatic t_read_no_index();
        logic a;
        bus_start();
        send_byte(8'hD3, a); chk("R11 read without index nack", a, 0);
        bus_stop();
        tick(Q);
        chk("R11 line released", sda_oe, 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_block_write();
        t_wrong_addr();
        t_zero_count();
        t_overrun();
        t_wrap();
        t_block_read();
        t_single();
        t_read_no_index();
        chk("R10 drive changes with clock high", hi_changes[7:0], 8'd0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule